// File: doc/BRIEF.md
# Bit-Serial Shift-Add Synaptic Column

The block is one column of a neural synapse array. A running activity total enters at the top of the column as a serial two's-complement word, least significant bit first. A marker bit travels alongside it and flags the cycle that carries the LSB. The column has a chain of pipelined synaptic operators. Each operator holds a signed weight and reads a small neural-state code from its own row. It then adds the weight, half the weight, or nothing to the passing total, or subtracts the weight or half the weight from it. The total that leaves the foot of the column is the sum of the column input and every operator's contribution.

There is no multiplier. Multiplying by one half is an arithmetic right shift of the weight by one bit. Negation uses inverted weight bits and a carry preset to one. Zero passes the total through unchanged. Each operator is therefore a one-bit serial adder with a carry flop, a bit counter and a small selector. Each operator registers the total and the marker once, so the column adds one cycle of delay per operator. Weights are written through a serial load chain that passes through all operators.

Top module: `syn_column`

## Requirements
- R1: While rst_ni is low, and afterwards until data reaches the foot of the column, sum_o and lsb_o are 0. Every weight resets to 0.
- R2: While load_en_i is high, load_bit_i shifts one bit per cycle into a chain that passes through all the weights. The weight of the last operator is loaded first, each weight LSB first. After N_SYN*W_WGT shifts, operator k holds the W_WGT bits written in group N_SYN-1-k.
- R3: While load_en_i is low, all weights hold their values, whatever load_bit_i does.
- R4: state_i[3k+2:3k] is the code of operator k. Bit 2 forces a zero contribution. Bit 1 selects half the weight. Bit 0 negates. The output word equals the input word plus the sum of all contributions.
- R5: With bits 2 and 1 clear, the contribution is +w (bit 0 = 0) or -w (bit 0 = 1). w is sign-extended to W_SUM bits.
- R6: With bit 2 clear and bit 1 set, the contribution is +(w>>>1) or -(w>>>1). The shift is an arithmetic right shift by one bit, so the result is rounded toward minus infinity.
- R7: With bit 2 set, the operator passes the total unchanged, whatever bits 1 and 0 are.
- R8: lsb_o repeats lsb_i delayed by exactly N_SYN cycles. Each output bit is also delayed by N_SYN cycles from its input bit, so a word takes N_SYN+W_SUM cycles to pass through completely.
- R9: Each operator captures its code in the cycle the LSB marker reaches it and uses that code for the whole word. Changes to state_i at other times have no effect on that word.
- R10: Words may follow each other with no gap. The carry of each operator starts over at every marker.
- R11: The result is taken modulo 2^W_SUM. Overflow wraps around without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sum_i | input | 1 | Serial running total in, LSB first |
| lsb_i | input | 1 | Marks the LSB cycle of sum_i |
| state_i | input | 3*N_SYN | Neural-state code per operator |
| load_en_i | input | 1 | Shift the weight load chain |
| load_bit_i | input | 1 | Serial weight data in |
| sum_o | output | 1 | Serial running total out |
| lsb_o | output | 1 | Marks the LSB cycle of sum_o |

## Verification
The hardest case to reach is a state code that changes in the middle of a word. Each operator latches its code only when the marker reaches it, and the marker reaches operators one cycle apart. A correct result therefore depends on which state value was on the bus at a different cycle for each operator. The stimulus draws a fresh random code for every operator on every cycle of back-to-back words. The expected word is computed from the codes present at cycle t0+k for operator k. An exhaustive sweep of all 256 weight values under all eight codes covers rounding of the negative half weight and the -128 corner.

// File: rtl/syn_col_pkg.sv
package syn_col_pkg;
  localparam int W_STATE = 3;

  // bit 2: force zero, bit 1: halve, bit 0: negate
  typedef struct packed {
    logic zero;
    logic half;
    logic neg;
  } state_t;
endpackage

// File: rtl/syn_weight_reg.sv
module syn_weight_reg #(
  parameter int W_WGT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             load_bit_i,
  output logic [W_WGT-1:0] wgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wgt_o <= '0;
    else if (load_en_i) wgt_o <= {load_bit_i, wgt_o[W_WGT-1:1]};
  end
endmodule

// File: rtl/syn_operator.sv
module syn_operator
  import syn_col_pkg::*;
#(
  parameter int W_WGT = 8,
  parameter int W_SUM = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sum_i,
  input  logic             lsb_i,
  input  state_t           state_i,
  input  logic [W_WGT-1:0] wgt_i,
  output logic             sum_o,
  output logic             lsb_o,
  output state_t           state_o
);
  localparam int W_IDX = $clog2(W_SUM);
  localparam int W_SRC = W_IDX + 1;
  localparam int W_WI  = $clog2(W_WGT);

  logic [W_IDX-1:0] idx_q, idx;
  logic [W_SRC-1:0] src;
  state_t           st_q, st_cur;
  logic             carry_q, cin, wbit, tbit, sum_d, carry_d;

  always_comb begin
    idx    = lsb_i ? '0 : idx_q;
    st_cur = lsb_i ? state_i : st_q;
    // halving reads one bit higher; past the MSB the sign repeats
    src    = {1'b0, idx} + {{(W_SRC-1){1'b0}}, st_cur.half};
    if (src < W_SRC'(W_WGT)) wbit = wgt_i[src[W_WI-1:0]];
    else                     wbit = wgt_i[W_WGT-1];
    tbit    = ~st_cur.zero & (wbit ^ st_cur.neg);
    cin     = lsb_i ? (st_cur.neg & ~st_cur.zero) : carry_q;
    sum_d   = sum_i ^ tbit ^ cin;
    carry_d = (sum_i & tbit) | (sum_i & cin) | (tbit & cin);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= 1'b0;
      lsb_o   <= 1'b0;
      carry_q <= 1'b0;
      idx_q   <= '0;
      st_q    <= '0;
    end else begin
      sum_o   <= sum_d;
      lsb_o   <= lsb_i;
      carry_q <= carry_d;
      idx_q   <= idx + 1'b1;
      st_q    <= st_cur;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/syn_column.sv
module syn_column
  import syn_col_pkg::*;
#(
  parameter int N_SYN = 4,
  parameter int W_WGT = 8,
  parameter int W_SUM = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sum_i,
  input  logic                     lsb_i,
  input  logic [N_SYN*W_STATE-1:0] state_i,
  input  logic                     load_en_i,
  input  logic                     load_bit_i,
  output logic                     sum_o,
  output logic                     lsb_o
);
  logic [N_SYN:0]              sum_chain;
  logic [N_SYN:0]              lsb_chain;
  logic [N_SYN-1:0]            ld_chain;
  logic [N_SYN-1:0][W_WGT-1:0] wgt_q;
  state_t [N_SYN-1:0]          st_cap;

  assign sum_chain[0] = sum_i;
  assign lsb_chain[0] = lsb_i;

  for (genvar k = 0; k < N_SYN; k++) begin : g_syn
    if (k == 0) begin : g_head
      assign ld_chain[k] = load_bit_i;
    end else begin : g_link
      assign ld_chain[k] = wgt_q[k-1][0];
    end

    syn_weight_reg #(.W_WGT(W_WGT)) u_wgt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_en_i  (load_en_i),
      .load_bit_i (ld_chain[k]),
      .wgt_o      (wgt_q[k])
    );

    syn_operator #(.W_WGT(W_WGT), .W_SUM(W_SUM)) u_op (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sum_i   (sum_chain[k]),
      .lsb_i   (lsb_chain[k]),
      .state_i (state_t'(state_i[k*W_STATE +: W_STATE])),
      .wgt_i   (wgt_q[k]),
      .sum_o   (sum_chain[k+1]),
      .lsb_o   (lsb_chain[k+1]),
      .state_o (st_cap[k])
    );
  end

  assign sum_o = sum_chain[N_SYN];
  assign lsb_o = lsb_chain[N_SYN];
endmodule

// File: rtl/syn_column_chk.sv
module syn_column_chk #(
  parameter int N_SYN = 4,
  parameter int W_WGT = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   load_en_i,
  input logic                   load_bit_i,
  input logic [N_SYN:0]         sum_chain,
  input logic [N_SYN:0]         lsb_chain,
  input logic [N_SYN*W_WGT-1:0] wgt_flat,
  input logic [N_SYN*3-1:0]     st_flat
);
  p_load_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(load_en_i)) |-> $stable(wgt_flat));

  p_load_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_en_i)) |-> wgt_flat[W_WGT-1] == $past(load_bit_i));

  for (genvar k = 0; k < N_SYN; k++) begin : g_chk
    p_lsb_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> lsb_chain[k+1] == $past(lsb_chain[k]));

    p_state_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(lsb_chain[k])) |-> $stable(st_flat[k*3 +: 3]));

    p_zero_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(lsb_chain[k]) && $past(st_flat[k*3+2]))
        |-> sum_chain[k+1] == $past(sum_chain[k]));
  end
endmodule

bind syn_column syn_column_chk #(.N_SYN(N_SYN), .W_WGT(W_WGT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_en_i  (load_en_i),
  .load_bit_i (load_bit_i),
  .sum_chain  (sum_chain),
  .lsb_chain  (lsb_chain),
  .wgt_flat   (wgt_q),
  .st_flat    (st_cap)
);

// File: tb/syn_column_tb.sv
`timescale 1ns/1ps
module syn_column_tb;
  localparam int N    = 4;
  localparam int WS   = 16;
  localparam int MAXW = 40;
  localparam int MAXC = MAXW*WS + N + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sum_i = 1'b0, lsb_i = 1'b0, load_en = 1'b0, load_bit = 1'b0;
  logic [N*3-1:0] state_i = '0;
  logic sum_o, lsb_o;

  int checks = 0, errors = 0;
  int wx[MAXW];
  logic [2:0] stc[MAXC][N];
  logic out_s[MAXC], out_l[MAXC];
  int wm[N];

  always #4 clk = ~clk;

  syn_column #(.N_SYN(N), .W_WGT(8), .W_SUM(WS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sum_i(sum_i), .lsb_i(lsb_i), .state_i(state_i),
    .load_en_i(load_en), .load_bit_i(load_bit), .sum_o(sum_o), .lsb_o(lsb_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int term(input int w, input logic [2:0] c);
    int m;
    if (c[2]) return 0;
    m = c[1] ? (w >>> 1) : w;
    return c[0] ? -m : m;
  endfunction

  task automatic load_weights(input int w[N]);
    for (int k = N-1; k >= 0; k--)
      for (int b = 0; b < 8; b++) begin
        @(negedge clk); load_en = 1'b1; load_bit = w[k][b];
      end
    @(negedge clk); load_en = 1'b0; load_bit = 1'b0;
    for (int k = 0; k < N; k++) wm[k] = w[k];
  endtask

  task automatic run_words(input int nw, input string req);
    int total, ex, got;
    logic lok;
    total = nw*WS + N + 1;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      out_s[c] = sum_o; out_l[c] = lsb_o;
      if (c < nw*WS) begin
        sum_i = wx[c/WS][c%WS];
        lsb_i = (c%WS == 0);
        for (int k = 0; k < N; k++) state_i[k*3 +: 3] = stc[c][k];
      end else begin
        sum_i = 1'b0; lsb_i = 1'b0; state_i = '0;
      end
    end
    for (int i = 0; i < nw; i++) begin
      int t0 = i*WS;
      ex = wx[i];
      for (int k = 0; k < N; k++) ex += term(wm[k], stc[t0+k][k]);
      ex &= 32'hFFFF;
      got = 0; lok = 1'b1;
      for (int b = 0; b < WS; b++) begin
        got[b] = out_s[t0+N+b];
        if (out_l[t0+N+b] != (b == 0)) lok = 1'b0;
      end
      chk(got == ex, req, got, ex);
      chk(lok, "R8 marker delay", int'(lok), 1);
    end
  endtask

  initial begin
    int w[N];
    @(negedge clk);
    chk(sum_o == 1'b0 && lsb_o == 1'b0, "R1 outputs in reset", {sum_o, lsb_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sum_o == 1'b0 && lsb_o == 1'b0, "R1 outputs after reset", {sum_o, lsb_o}, 0);
    // weights reset to zero: a +1 code leaves the total unchanged
    for (int k = 0; k < N; k++) wm[k] = 0;
    wx[0] = 16'h1234;
    for (int c = 0; c < WS; c++) for (int k = 0; k < N; k++) stc[c][k] = 3'b000;
    run_words(1, "R1 zero weights");

    // exhaustive weight sweep under all eight codes
    for (int v = 0; v < 256; v++) begin
      for (int k = 0; k < N; k++) w[k] = int'($signed(8'(v + 37*k)));
      load_weights(w);
      for (int j = 0; j < 8; j++) begin
        wx[j] = int'($urandom & 32'hFFFF);
        for (int b = 0; b < WS; b++)
          for (int k = 0; k < N; k++) stc[j*WS+b][k] = 3'((j + k) % 8);
      end
      run_words(8, "R2 R4 R5 R6 R7 sweep");
    end

    // weights held with load disabled while load_bit toggles
    w = '{-128, 127, -1, 64};
    load_weights(w);
    for (int i = 0; i < 20; i++) begin @(negedge clk); load_bit = ~load_bit; end
    load_bit = 1'b0;
    for (int j = 0; j < 4; j++) begin
      wx[j] = int'($urandom & 32'hFFFF);
      for (int b = 0; b < WS; b++) for (int k = 0; k < N; k++) stc[j*WS+b][k] = 3'(j);
    end
    run_words(4, "R3 hold");

    // wraparound: positive overflow and -(-128) terms
    w = '{127, 127, 127, 127};
    load_weights(w);
    wx[0] = 16'hFFF0; wx[1] = 16'h7FFF; wx[2] = 16'h0000;
    for (int j = 0; j < 3; j++)
      for (int b = 0; b < WS; b++) for (int k = 0; k < N; k++) stc[j*WS+b][k] = (j == 2) ? 3'b001 : 3'b000;
    run_words(3, "R11 wrap");
    w = '{-128, -128, -128, -128};
    load_weights(w);
    wx[0] = 16'hFF00; wx[1] = 16'h0000;
    for (int b = 0; b < WS; b++) for (int k = 0; k < N; k++) begin
      stc[b][k] = 3'b001; stc[WS+b][k] = 3'b011;
    end
    run_words(2, "R11 wrap negate");

    // state codes changing every cycle, back-to-back words
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < N; k++) w[k] = int'($signed(8'($urandom)));
      load_weights(w);
      for (int j = 0; j < 32; j++) begin
        wx[j] = int'($urandom & 32'hFFFF);
        for (int b = 0; b < WS; b++) for (int k = 0; k < N; k++) stc[j*WS+b][k] = 3'($urandom);
      end
      run_words(32, "R9 R10 mid-word codes");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule